// File: doc/BRIEF.md
# I2S Serial Audio Transmitter

This block turns stereo sample pairs into an I2S-style serial stream. It runs entirely on one source clock. From that clock it derives a master clock and a bit clock by counting cycles, and from the bit clock it derives the word-select signal. At the start of every frame it takes one left/right pair from an upstream first-word-fall-through FIFO. It then shifts the left word and the right word out, most significant bit first. If no pair is waiting at a frame boundary, the frame carries zeros and a one-cycle underrun pulse is raised.

A two-bit channel mode selects, for each word, whether the slot carries its sample or is forced to zero. A mode change that arrives while a word is being shifted is held back until that word has finished. The circuit enable runs the dividers and the framing. The output enable only decides what reaches the pins. While output is disabled, the master clock and word select are held low, the bit clock rests at the polarity level, and the serial data pin keeps its last value. Divider ratios and the sample width are captured only while the circuit is disabled.

Top module: `i2s_tx`

## Requirements
- R1: While `en` is 1 and `oe` is 1, `mclk_o` toggles every `mclk_half` source-clock cycles and `bclk_o` toggles every `bclk_half` cycles. A ratio of 0 acts as 1. Ratio inputs are captured only while `en` is 0, so a change made while `en` is 1 leaves the toggle interval unchanged.
- R2: In each frame the left slot comes first and the right slot second, each one word long. Data is sent MSB first. `sd_o` changes on the falling edge of the internal bit clock and is stable at its rising edge. `ws_o` is 0 for the left slot and 1 for the right slot, and it changes one bit clock before each word's MSB.
- R3: With `w24`=1 a word is 24 bits, taken from sample bits [23:0]. With `w24`=0 a word is 16 bits, taken from bits [15:0], and bits [23:16] are ignored. `w24` is captured only while `en` is 0.
- R4: `chan_mode` encoding: 0 sends both slots, 1 sends the right slot and zeros the left, 2 sends the left slot and zeros the right, 3 zeros both slots.
- R5: `chan_mode` is sampled at the start of each word. A change made in the middle of a word leaves that word intact and applies from the next word on.
- R6: A pair is taken from `fifo_left`/`fifo_right` at the start of each frame in which `fifo_valid` is 1. `fifo_pop` is a one-cycle pulse in the next source-clock cycle, with exactly one pop per frame.
- R7: If `fifo_valid` is 0 at a frame start, both slots of that frame are zero, no pop occurs, and `underrun` pulses high for exactly one cycle.
- R8: With `en` at 1, frames keep advancing and pairs keep being popped even while `oe` is 0.
- R9: While `oe` is 0, `mclk_o` and `ws_o` are 0 and `sd_o` holds its last value.
- R10: While `oe` is 0, `bclk_o` equals `bclk_pol`. While `oe` is 1, `bclk_o` is the internal bit clock inverted when `bclk_pol` is 1. Polarity does not change the divide interval.
- R11: After reset, all outputs are 0 when `bclk_pol` is 0.
- R12: While `en` is 0, the internal clocks and word select rest low, so with `oe`=1 `mclk_o` and `ws_o` are 0 and `bclk_o` equals `bclk_pol`. After `en` rises, the first complete word is a left word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Circuit enable: runs dividers and framing |
| oe | input | 1 | Output enable for the pins |
| bclk_pol | input | 1 | Bit-clock pin polarity |
| chan_mode | input | 2 | Channel mode (see R4) |
| w24 | input | 1 | 1 = 24-bit words, 0 = 16-bit words |
| mclk_half | input | DIVW | Master-clock half period in source cycles |
| bclk_half | input | DIVW | Bit-clock half period in source cycles |
| fifo_valid | input | 1 | A sample pair is available |
| fifo_left | input | SAMPW | Left sample of the pair at the FIFO head |
| fifo_right | input | SAMPW | Right sample of the pair at the FIFO head |
| fifo_pop | output | 1 | One-cycle pulse: head pair consumed |
| underrun | output | 1 | One-cycle pulse: frame started with no pair |
| mclk_o | output | 1 | Master clock pin |
| bclk_o | output | 1 | Bit clock pin |
| ws_o | output | 1 | Word select pin |
| sd_o | output | 1 | Serial data pin |

## Verification
Every pin is registered once after the internal divider and shifter state, so a pin reflects an internal change one source cycle later. `fifo_pop` and `underrun` likewise rise the cycle after the frame-start edge that took the pair. The bench drives inputs and samples outputs on the falling source-clock edge. It rebuilds words with a receiver model that samples `sd_o` and `ws_o` on the pin's rising bit-clock edge, so the checks follow the stream rather than counting cycles. Output-disable and disable effects are checked over long windows that begin two cycles after the change, which covers the one-cycle pin latency. Mode changes are made in the middle of a word, far from any word boundary.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef enum logic [1:0] {
    CHM_BOTH   = 2'd0,
    CHM_RIGHT  = 2'd1,
    CHM_LEFT   = 2'd2,
    CHM_SILENT = 2'd3
  } chan_mode_e;

  // Does the given slot (0 = left, 1 = right) carry its sample under mode m?
  function automatic logic slot_live(input chan_mode_e m, input logic right_slot);
    case (m)
      CHM_BOTH:  slot_live = 1'b1;
      CHM_RIGHT: slot_live = right_slot;
      CHM_LEFT:  slot_live = ~right_slot;
      default:   slot_live = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/i2s_clk_div.sv
module i2s_clk_div #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] half,
  output logic            level,
  output logic            fall_tick
);

  logic [DIVW-1:0] cnt;
  logic            wrap;

  assign wrap      = (cnt == half - DIVW'(1));
  assign fall_tick = run && wrap && level;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      level <= ~level;
    end else begin
      cnt <= cnt + DIVW'(1);
    end
  end

endmodule

// File: rtl/i2s_frame_shift.sv
module i2s_frame_shift
  import i2s_tx_pkg::*;
#(
  parameter int SAMPW = 24,
  parameter int NARW  = 16,
  parameter int CNTW  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step,
  input  logic             wide,
  input  chan_mode_e       mode,
  input  logic             pair_ok,
  input  logic [SAMPW-1:0] left_in,
  input  logic [SAMPW-1:0] right_in,
  output logic             sd,
  output logic             ws,
  output logic             take,
  output logic             starve
);

  localparam logic [CNTW-1:0] LAST_W = CNTW'(2*SAMPW - 1);
  localparam logic [CNTW-1:0] LAST_N = CNTW'(2*NARW - 1);
  localparam logic [CNTW-1:0] WORD_W = CNTW'(SAMPW);
  localparam logic [CNTW-1:0] WORD_N = CNTW'(NARW);
  localparam int              PAD    = SAMPW - NARW;

  logic [CNTW-1:0]  pos, pos_n, last, word_len;
  logic [SAMPW-1:0] shreg, rbuf, lnew, rnew;
  logic             frame_start, right_start;

  function automatic logic [SAMPW-1:0] justify(input logic [SAMPW-1:0] d, input logic wd);
    justify = wd ? d : (d << PAD);
  endfunction

  assign last        = wide ? LAST_W : LAST_N;
  assign word_len    = wide ? WORD_W : WORD_N;
  assign pos_n       = (pos == last) ? '0 : pos + CNTW'(1);
  assign frame_start = step && (pos_n == '0);
  assign right_start = step && (pos_n == word_len);
  assign take        = frame_start && pair_ok;
  assign starve      = frame_start && !pair_ok;
  assign lnew        = pair_ok ? left_in  : '0;
  assign rnew        = pair_ok ? right_in : '0;
  assign sd          = shreg[SAMPW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= LAST_W;
      ws    <= 1'b0;
      shreg <= '0;
      rbuf  <= '0;
    end else if (!run) begin
      pos <= last;
      ws  <= 1'b0;
    end else if (step) begin
      pos <= pos_n;
      // Word select leads the data by one bit clock.
      ws  <= (pos_n >= word_len - CNTW'(1)) && (pos_n != last);
      if (frame_start) begin
        rbuf  <= rnew;
        shreg <= slot_live(mode, 1'b0) ? justify(lnew, wide) : '0;
      end else if (right_start) begin
        shreg <= slot_live(mode, 1'b1) ? justify(rbuf, wide) : '0;
      end else begin
        shreg <= shreg << 1;
      end
    end
  end

endmodule

// File: rtl/i2s_pin_gate.sv
module i2s_pin_gate (
  input  logic clk,
  input  logic rst,
  input  logic oe,
  input  logic pol,
  input  logic mclk_i,
  input  logic bclk_i,
  input  logic ws_i,
  input  logic sd_i,
  output logic mclk_o,
  output logic bclk_o,
  output logic ws_o,
  output logic sd_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mclk_o <= 1'b0;
      bclk_o <= 1'b0;
      ws_o   <= 1'b0;
      sd_o   <= 1'b0;
    end else begin
      mclk_o <= oe & mclk_i;
      ws_o   <= oe & ws_i;
      bclk_o <= oe ? (bclk_i ^ pol) : pol;
      if (oe) begin
        sd_o <= sd_i;
      end
    end
  end

endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
  import i2s_tx_pkg::*;
#(
  parameter int SAMPW = 24,
  parameter int NARW  = 16,
  parameter int DIVW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             oe,
  input  logic             bclk_pol,
  input  logic [1:0]       chan_mode,
  input  logic             w24,
  input  logic [DIVW-1:0]  mclk_half,
  input  logic [DIVW-1:0]  bclk_half,
  input  logic             fifo_valid,
  input  logic [SAMPW-1:0] fifo_left,
  input  logic [SAMPW-1:0] fifo_right,
  output logic             fifo_pop,
  output logic             underrun,
  output logic             mclk_o,
  output logic             bclk_o,
  output logic             ws_o,
  output logic             sd_o
);

  localparam int NDIV = 2;   // index 0: master clock, index 1: bit clock
  localparam int CNTW = $clog2(2*SAMPW);

  logic [DIVW-1:0] half_q [NDIV];
  logic [DIVW-1:0] half_in [NDIV];
  logic [NDIV-1:0] lvl_v, fall_v;
  logic            wide_q;
  logic            unused_mclk_fall;
  logic            sd_int, ws_int, take, starve;

  assign half_in[0]       = mclk_half;
  assign half_in[1]       = bclk_half;
  assign unused_mclk_fall = fall_v[0];

  // Ratios and width are captured only while the circuit is off.
  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q <= 1'b1;
    end else if (!en) begin
      wide_q <= w24;
    end
  end

  generate
    for (genvar g = 0; g < NDIV; g++) begin : g_div
      always_ff @(posedge clk) begin
        if (rst) begin
          half_q[g] <= DIVW'(1);
        end else if (!en) begin
          half_q[g] <= (half_in[g] == '0) ? DIVW'(1) : half_in[g];
        end
      end

      i2s_clk_div #(.DIVW(DIVW)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (en),
        .half      (half_q[g]),
        .level     (lvl_v[g]),
        .fall_tick (fall_v[g])
      );
    end
  endgenerate

  i2s_frame_shift #(.SAMPW(SAMPW), .NARW(NARW), .CNTW(CNTW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .run      (en),
    .step     (fall_v[1]),
    .wide     (wide_q),
    .mode     (chan_mode_e'(chan_mode)),
    .pair_ok  (fifo_valid),
    .left_in  (fifo_left),
    .right_in (fifo_right),
    .sd       (sd_int),
    .ws       (ws_int),
    .take     (take),
    .starve   (starve)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_pop <= 1'b0;
      underrun <= 1'b0;
    end else begin
      fifo_pop <= take;
      underrun <= starve;
    end
  end

  i2s_pin_gate u_pins (
    .clk    (clk),
    .rst    (rst),
    .oe     (oe),
    .pol    (bclk_pol),
    .mclk_i (lvl_v[0]),
    .bclk_i (lvl_v[1]),
    .ws_i   (ws_int),
    .sd_i   (sd_int),
    .mclk_o (mclk_o),
    .bclk_o (bclk_o),
    .ws_o   (ws_o),
    .sd_o   (sd_o)
  );

endmodule

// File: rtl/i2s_tx_sva.sv
module i2s_tx_sva (
  input logic clk,
  input logic rst,
  input logic en,
  input logic oe,
  input logic bclk_pol,
  input logic fifo_pop,
  input logic underrun,
  input logic mclk_o,
  input logic bclk_o,
  input logic ws_o,
  input logic sd_o
);

  AST_OE_OFF_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !oe |=> (!mclk_o && !ws_o)); // R9

  AST_OE_OFF_SD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !oe |=> $stable(sd_o)); // R9

  AST_OE_OFF_BCLK_REST: assert property (@(posedge clk) disable iff (rst)
    !oe |=> (bclk_o == $past(bclk_pol))); // R10

  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop); // R6

  AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun); // R7

  AST_POP_NOT_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
    !(fifo_pop && underrun)); // R7

  AST_OFF_CLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en ##1 !en |=> (!mclk_o && !ws_o)); // R12

endmodule

bind i2s_tx i2s_tx_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .oe       (oe),
  .bclk_pol (bclk_pol),
  .fifo_pop (fifo_pop),
  .underrun (underrun),
  .mclk_o   (mclk_o),
  .bclk_o   (bclk_o),
  .ws_o     (ws_o),
  .sd_o     (sd_o)
);

// File: tb/tb_i2s_tx.sv
module tb_i2s_tx;

  localparam int SAMPW = 24;
  localparam int DIVW  = 8;

  typedef struct packed {
    logic        wide;
    logic [1:0]  mode;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 2'd0, 24'hA5C3E1, 24'h0F1E2D},
    '{1'b1, 2'd1, 24'h800001, 24'hFEDCBA},
    '{1'b1, 2'd2, 24'h7E5A3C, 24'hC00003},
    '{1'b1, 2'd3, 24'hFFFFFF, 24'hFFFFFF},
    '{1'b0, 2'd0, 24'h5AC3A5, 24'hE18001},
    '{1'b0, 2'd1, 24'hFF8001, 24'h11B00D},
    '{1'b0, 2'd2, 24'h33F00F, 24'hAA4321},
    '{1'b0, 2'd3, 24'hFFFFFF, 24'h12FFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, oe = 1'b0, bclk_pol = 1'b0, w24 = 1'b1;
  logic [1:0] chan_mode = 2'd0;
  logic [DIVW-1:0] mclk_half = 8'd2, bclk_half = 8'd2;
  logic fifo_valid;
  logic [SAMPW-1:0] fifo_left, fifo_right;
  logic fifo_pop, underrun, mclk_o, bclk_o, ws_o, sd_o;

  always #2.5 clk = ~clk;

  // FIFO model
  logic [23:0] fl [0:15];
  logic [23:0] fr [0:15];
  int fcount = 0;
  int fidx   = 0;
  assign fifo_valid = (fidx < fcount);
  assign fifo_left  = fl[fidx[3:0]];
  assign fifo_right = fr[fidx[3:0]];
  always @(posedge clk) if (fifo_pop) fidx <= fidx + 1;

  i2s_tx #(.SAMPW(SAMPW), .NARW(16), .DIVW(DIVW)) dut (
    .clk(clk), .rst(rst), .en(en), .oe(oe), .bclk_pol(bclk_pol),
    .chan_mode(chan_mode), .w24(w24), .mclk_half(mclk_half), .bclk_half(bclk_half),
    .fifo_valid(fifo_valid), .fifo_left(fifo_left), .fifo_right(fifo_right),
    .fifo_pop(fifo_pop), .underrun(underrun),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o), .sd_o(sd_o)
  );

  int checks = 0;
  int errors = 0;

  // Receiver model: samples on the rising edge of the non-inverted bit clock.
  logic [23:0] rx_word [0:15];
  logic        rx_ch   [0:15];
  logic [23:0] acc = '0;
  logic        rx_ws = 1'b0, prev_b = 1'b0, und_prev = 1'b0;
  int rx_n = 0, rx_cnt = 0, pop_cnt = 0, und_cnt = 0, und_long = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (fifo_pop) pop_cnt++;
      if (underrun) und_cnt++;
      if (underrun && und_prev) und_long++;
      und_prev = underrun;
      if (oe && ((bclk_o ^ bclk_pol) == 1'b1) && ((prev_b ^ bclk_pol) == 1'b0)) begin
        acc = {acc[22:0], sd_o};
        rx_cnt++;
        if (ws_o != rx_ws) begin
          if (rx_n < 16) begin
            rx_word[rx_n] = w24 ? acc : {8'h00, acc[15:0]};
            rx_ch[rx_n]   = rx_ws;
          end
          rx_n++;
          rx_cnt = 0;
        end
        rx_ws = ws_o;
      end
    end
    prev_b = bclk_o;
  end

  task automatic clear_rx();
    rx_n = 0; rx_cnt = 0; rx_ws = 1'b0; pop_cnt = 0; und_cnt = 0; und_long = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rx(input int n);
    int g = 0;
    while (rx_n < n && g < 8000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic meas(input bit use_m, output int n);
    logic last;
    int c = 0;
    @(negedge clk);
    last = use_m ? mclk_o : bclk_o;
    while ((use_m ? mclk_o : bclk_o) == last && c < 300) begin @(negedge clk); c++; end
    last = use_m ? mclk_o : bclk_o;
    n = 0;
    while ((use_m ? mclk_o : bclk_o) == last && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic stop_and_clear();
    en = 1'b0;
    cycles(6);
    clear_rx();
  endtask

  function automatic logic [23:0] msk(input logic wd, input logic [23:0] x);
    return wd ? x : {8'h00, x[15:0]};
  endfunction

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    int bad_m, bad_w, bad_b, bad_s, pops0;
    logic held;
    logic [23:0] exp_l, exp_r;

    for (int i = 0; i < 16; i++) begin fl[i] = '0; fr[i] = '0; end
    cycles(4);
    rst = 1'b0;
    cycles(1);
    // R11: reset state of every output
    chk("R11 reset outputs", {26'd0, fifo_pop, underrun, mclk_o, bclk_o, ws_o, sd_o}, 32'd0);

    // Vector table: R2 R3 R4 R6 R12
    oe = 1'b1; mclk_half = 8'd3; bclk_half = 8'd2;
    for (int i = 0; i < 8; i++) begin
      stop_and_clear();
      w24 = VECS[i].wide; chan_mode = VECS[i].mode;
      fcount = 3; fidx = 0;
      for (int k = 0; k < 3; k++) begin
        fl[k] = 24'(VECS[i].l + 24'h010203 * k);
        fr[k] = 24'(VECS[i].r + 24'h030201 * k);
      end
      cycles(2);
      en = 1'b1;
      wait_rx(6);
      en = 1'b0;
      for (int k = 0; k < 3; k++) begin
        exp_l = (VECS[i].mode == 2'd0 || VECS[i].mode == 2'd2) ? msk(VECS[i].wide, fl[k]) : 24'h0;
        exp_r = (VECS[i].mode == 2'd0 || VECS[i].mode == 2'd1) ? msk(VECS[i].wide, fr[k]) : 24'h0;
        chk($sformatf("R2/R3/R4 vec%0d frame%0d left", i, k), {8'h0, rx_word[2*k]}, {8'h0, exp_l});
        chk($sformatf("R2/R3/R4 vec%0d frame%0d right", i, k), {8'h0, rx_word[2*k+1]}, {8'h0, exp_r});
        chk($sformatf("R2 R12 vec%0d slot order %0d", i, k), {30'd0, rx_ch[2*k], rx_ch[2*k+1]}, 32'd1);
      end
      chk($sformatf("R6 vec%0d pops", i), pop_cnt, 32'd3);
    end

    // R12: disabled with output on -> clocks and word select idle
    stop_and_clear();
    bad_m = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (mclk_o !== 1'b0 || ws_o !== 1'b0 || bclk_o !== bclk_pol) bad_m++;
    end
    chk("R12 idle pins while disabled", bad_m, 0);

    // R1: divide intervals, capture only while disabled, zero acts as one
    mclk_half = 8'd3; bclk_half = 8'd5; w24 = 1'b1; fcount = 0; fidx = 0;
    cycles(2);
    en = 1'b1;
    meas(1'b1, n); chk("R1 mclk half period", n, 3);
    meas(1'b0, n); chk("R1 bclk half period", n, 5);
    bclk_half = 8'd2;
    cycles(3);
    meas(1'b0, n); chk("R1 ratio change while enabled ignored", n, 5);
    stop_and_clear();
    bclk_half = 8'd0;
    cycles(2);
    en = 1'b1;
    meas(1'b0, n); chk("R1 zero ratio acts as one", n, 1);

    // R5: mode change mid-word applies from next word
    stop_and_clear();
    w24 = 1'b0; chan_mode = 2'd0; bclk_half = 8'd2;
    fcount = 4; fidx = 0;
    for (int k = 0; k < 4; k++) begin
      fl[k] = 24'(24'h00C3A5 + 24'h001111 * k);
      fr[k] = 24'(24'h009A5B + 24'h002222 * k);
    end
    cycles(2);
    en = 1'b1;
    begin
      int g = 0;
      while (!(rx_n == 2 && rx_cnt == 5) && g < 4000) begin @(negedge clk); g++; end
    end
    chan_mode = 2'd3;
    wait_rx(6);
    chk("R5 word before change", {8'h0, rx_word[0]}, {16'h0, fl[0][15:0]});
    chk("R5 word in progress intact", {8'h0, rx_word[2]}, {16'h0, fl[1][15:0]});
    chk("R5 next word muted", {8'h0, rx_word[3]}, 32'd0);
    chk("R5 later words muted", {8'h0, rx_word[4] | rx_word[5]}, 32'd0);
    chan_mode = 2'd0;

    // R7: underrun
    stop_and_clear();
    w24 = 1'b0; bclk_half = 8'd1;
    fcount = 1; fidx = 0; fl[0] = 24'h00F00F; fr[0] = 24'h00A00A;
    cycles(2);
    en = 1'b1;
    wait_rx(4);
    chk("R7 first frame data", {8'h0, rx_word[1]}, 32'h0000A00A);
    chk("R7 starved frame zero", {8'h0, rx_word[2] | rx_word[3]}, 32'd0);
    chk("R7 underrun pulsed", {31'd0, und_cnt > 0}, 32'd1);
    chk("R7 underrun single cycle", und_long, 0);
    chk("R7 no pop when empty", pop_cnt, 1);

    // R8 R9 R10: output disable
    stop_and_clear();
    w24 = 1'b0; bclk_half = 8'd1; mclk_half = 8'd2; bclk_pol = 1'b0;
    fcount = 12; fidx = 0;
    for (int k = 0; k < 12; k++) begin fl[k] = 24'h00FFFF; fr[k] = 24'h005555; end
    cycles(2);
    en = 1'b1;
    wait_rx(1);
    oe = 1'b0;
    cycles(2);
    held = sd_o; pops0 = pop_cnt;
    bad_m = 0; bad_w = 0; bad_b = 0; bad_s = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (mclk_o !== 1'b0) bad_m++;
      if (ws_o !== 1'b0) bad_w++;
      if (bclk_o !== 1'b0) bad_b++;
      if (sd_o !== held) bad_s++;
    end
    chk("R9 mclk held low", bad_m, 0);
    chk("R9 ws held low", bad_w, 0);
    chk("R9 sd holds last", bad_s, 0);
    chk("R10 bclk rests at pol 0", bad_b, 0);
    chk("R8 pops continue with output off", {31'd0, pop_cnt > pops0}, 32'd1);
    bclk_pol = 1'b1;
    cycles(2);
    bad_b = 0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (bclk_o !== 1'b1) bad_b++;
    end
    chk("R10 bclk rests at pol 1", bad_b, 0);
    en = 1'b0;
    bclk_half = 8'd3;
    cycles(2);
    en = 1'b1;
    oe = 1'b1;
    meas(1'b0, n);
    chk("R10 inverted bclk keeps interval", n, 3);

    finish_run();
  end

endmodule